// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Interrupt Logic

This block sits between an infrared pulse sampler and a processor bus. The sampler hands it run-length bytes, one per cycle when `smp_valid` is high, and marks the end of a received burst with a one-cycle `smp_pkt_end` pulse. The bytes are held in a first-in first-out store whose depth is a parameter (16 or 64 in practice). Software reads them oldest first through a 32-bit register window. The same window holds the interrupt enables, a fill threshold, and a status word.

The status word mixes three kinds of field. Overflow and packet-end are sticky event flags that software clears by writing ones. Data-available follows the live occupancy, judged against the programmed threshold rather than against non-empty. The current occupancy is also reported as a count field. A single registered interrupt line is the OR of every enabled flag.

Register offsets on `reg_addr`: 0x0 data (read pops), 0x4 interrupt control, 0x8 status. All other offsets read as zero and ignore writes. Reads return their value on `reg_rdata` in the cycle after `reg_rd` is sampled.

Top module: `ir_rx_fifo`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, `irq` is low and `reg_rdata` is 0.
- R2: A read of offset 0x0 returns the oldest stored byte in bits 7:0, with bits 31:8 zero, and removes that byte. Bytes come out in arrival order.
- R3: A read of offset 0x0 while the store is empty returns 0 and leaves the occupancy at 0.
- R4: Status bits starting at bit 8 (width log2(DEPTH)+1) hold the current number of stored bytes.
- R5: A byte presented while the store holds DEPTH bytes, with no data read in the same cycle, is dropped. The stored contents are kept unchanged, and status bit 0 (overflow) is set and stays set.
- R6: A `smp_pkt_end` pulse sets status bit 1 (packet end), which stays set.
- R7: Status bit 4 (available) is 1 exactly while the occupancy is greater than the level field of the control word (bits starting at bit 8, same width as the count). Writes to the status word do not affect it.
- R8: A write to status offset 0x8 clears bit 0 and/or bit 1 where the written data has a 1. Bits written 0 stay unchanged, and 0xFF clears both. An event in the same cycle as its clear wins.
- R9: `irq` goes high one cycle after any status flag (bits 0, 1, 4) is high while its enable in the control word (the same bit position) is 1, and is low otherwise.
- R10: The control word at offset 0x4 reads back the enables (bits 0, 1, 4) and the level field as last written; all other bits read 0.
- R11: When the store is full, a byte presented in the same cycle as a data read is accepted, and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | 8 | Run-length byte from the sampler |
| smp_pkt_end | input | 1 | One-cycle end-of-burst pulse |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is a data read and a sampler byte landing on the same edge while the store is exactly full. In that case the byte must be accepted rather than counted as overflow. The bench fills the store to DEPTH, then raises `reg_rd` at the data offset and `smp_valid` in the same cycle. It then checks the popped value, the unchanged count and the clear overflow bit, and drains the store to confirm that the new byte landed last. Overflow itself is reached by pushing two bytes past full and draining, to show that no dropped byte got in.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

  // bit positions shared by control (enables) and status (flags)
  localparam int BIT_OVF   = 0;
  localparam int BIT_PEND  = 1;
  localparam int BIT_AVAIL = 4;
  localparam int FLD_LSB   = 8;

  typedef struct packed {
    logic ovf;
    logic pend;
    logic avail;
  } flags_t;
endpackage

// File: rtl/irf_store.sv
module irf_store #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop_req,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       rd_q,
  output logic             ovf_ev
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             empty, full, pop, acc;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == FULL_CNT);
  assign pop    = pop_req && !empty;
  assign acc    = push && (!full || pop);
  assign ovf_ev = push && full && !pop;
  assign count  = cnt_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (pop_req) begin
      rd_q <= empty ? 8'h00 : mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (acc) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({acc, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);
  // R5
  drop_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_req) |=> $stable(cnt_q));
  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push && empty) |=> (cnt_q == '0));
  // R11
  pushpop_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop_req && full) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/irf_events.sv
module irf_events
  import ir_rx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf_ev,
  input  logic             pend_ev,
  input  logic             clr_wr,
  input  logic [7:0]       clr_mask,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  input  flags_t           en,
  output flags_t           flags,
  output logic             irq
);
  logic ovf_q, pend_q, avail, irq_q;

  assign avail = (count > level);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ovf_ev)                           ovf_q <= 1'b1;
      else if (clr_wr && clr_mask[BIT_OVF]) ovf_q <= 1'b0;
      if (pend_ev)                           pend_q <= 1'b1;
      else if (clr_wr && clr_mask[BIT_PEND]) pend_q <= 1'b0;
      irq_q <= (ovf_q && en.ovf) || (pend_q && en.pend) || (avail && en.avail);
    end
  end

  assign flags = '{ovf: ovf_q, pend: pend_q, avail: avail};
  assign irq   = irq_q;

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> ovf_q);
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    pend_ev |=> pend_q);
  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_mask[BIT_OVF] && !ovf_ev) |=> !ovf_q);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq_q);
endmodule

// File: rtl/irf_regs.sv
module irf_regs
  import ir_rx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  count,
  input  flags_t            flags,
  input  logic [7:0]        store_q,
  output logic [31:0]       rdata,
  output logic              pop_req,
  output logic              clr_wr,
  output flags_t            en,
  output logic [CNT_W-1:0]  level
);
  flags_t           en_q;
  logic [CNT_W-1:0] lvl_q;
  logic [31:0]      reg_q, ctl_word, stat_word;
  logic             data_sel_q;

  assign pop_req = rd && (addr == OFS_DATA);
  assign clr_wr  = wr && (addr == OFS_STAT);
  assign en      = en_q;
  assign level   = lvl_q;

  always_comb begin
    ctl_word = '0;
    ctl_word[BIT_OVF]   = en_q.ovf;
    ctl_word[BIT_PEND]  = en_q.pend;
    ctl_word[BIT_AVAIL] = en_q.avail;
    ctl_word[FLD_LSB +: CNT_W] = lvl_q;
    stat_word = '0;
    stat_word[BIT_OVF]   = flags.ovf;
    stat_word[BIT_PEND]  = flags.pend;
    stat_word[BIT_AVAIL] = flags.avail;
    stat_word[FLD_LSB +: CNT_W] = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      lvl_q <= '0;
    end else if (wr && (addr == OFS_CTL)) begin
      en_q  <= '{ovf: wdata[BIT_OVF], pend: wdata[BIT_PEND], avail: wdata[BIT_AVAIL]};
      lvl_q <= wdata[FLD_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      data_sel_q <= 1'b0;
    end else if (rd) begin
      data_sel_q <= (addr == OFS_DATA);
      case (addr)
        OFS_CTL:  reg_q <= ctl_word;
        OFS_STAT: reg_q <= stat_word;
        default:  reg_q <= '0;
      endcase
    end
  end

  assign rdata = data_sel_q ? {24'h0, store_q} : reg_q;

  // R10
  ctl_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_CTL) |=> (lvl_q == $past(wdata[FLD_LSB +: CNT_W])));
  // R2
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    data_sel_q |-> (rdata[31:8] == 24'h0));
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        smp_valid,
  input  logic [7:0]  smp_byte,
  input  logic        smp_pkt_end,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  generate
    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two");
    end
  endgenerate

  logic [CNT_W-1:0] count, level;
  logic [7:0]       store_q;
  logic             ovf_ev, pop_req, clr_wr;
  flags_t           flags, en;

  irf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .push(smp_valid), .push_data(smp_byte),
    .pop_req(pop_req), .count(count), .rd_q(store_q), .ovf_ev(ovf_ev)
  );

  irf_events #(.CNT_W(CNT_W)) u_events (
    .clk(clk), .rst(rst), .ovf_ev(ovf_ev), .pend_ev(smp_pkt_end),
    .clr_wr(clr_wr), .clr_mask(reg_wdata[7:0]), .count(count),
    .level(level), .en(en), .flags(flags), .irq(irq)
  );

  irf_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .count(count), .flags(flags), .store_q(store_q),
    .rdata(reg_rdata), .pop_req(pop_req), .clr_wr(clr_wr), .en(en),
    .level(level)
  );
endmodule

// File: tb/ir_rx_fifo_test.sv
module ir_rx_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic        clk = 0, rst = 1;
  logic        smp_valid = 0, smp_pkt_end = 0, reg_rd = 0, reg_wr = 0;
  logic [7:0]  smp_byte = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  ir_rx_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_byte(smp_byte),
    .smp_pkt_end(smp_pkt_end), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic push(input logic [7:0] d);
    smp_valid = 1; smp_byte = d;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] s);
    return 32'(s[8 +: CNT_W]);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", 32'(irq), 0);
    rd(4'h8, v); chk("R1 status", v, 0);
    rd(4'h4, v); chk("R1 ctl", v, 0);
    rd(4'h0, v); chk("R3 empty read", v, 0);
    rd(4'h8, v); chk("R3 count after empty read", cnt_of(v), 0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    push(8'hA1); push(8'h5B); push(8'hC3);
    rd(4'h8, v); chk("R4 count 3", cnt_of(v), 3);
    rd(4'h0, v); chk("R2 first", v, 32'hA1);
    rd(4'h0, v); chk("R2 second", v, 32'h5B);
    rd(4'h8, v); chk("R4 count 1", cnt_of(v), 1);
    rd(4'h0, v); chk("R2 third", v, 32'hC3);
    rd(4'h0, v); chk("R3 read past empty", v, 0);
    rd(4'h8, v); chk("R3 count stays 0", cnt_of(v), 0);
  endtask

  task automatic t_ctl;
    logic [31:0] v;
    wr(4'h4, 32'h0000_0713);
    rd(4'h4, v); chk("R10 ctl readback", v, 32'h0000_0713);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); chk("R10 ctl masked", v, 32'h0000_1F13);
    wr(4'h4, 0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R10 unmapped reads 0", v, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(4'h4, 32'h10 | ((DEPTH/2 - 1) << 8));
    for (int i = 0; i < DEPTH/2 - 1; i++) push(8'(i));
    idle;
    rd(4'h8, v); chk("R7 avail low at level", 32'(v[4]), 0);
    chk("R9 irq low at level", 32'(irq), 0);
    push(8'h77);
    rd(4'h8, v); chk("R7 avail above level", 32'(v[4]), 1);
    chk("R9 irq on avail", 32'(irq), 1);
    wr(4'h8, 32'hFF);
    rd(4'h8, v); chk("R7 avail unaffected by clear", 32'(v[4]), 1);
    rd(4'h0, v);
    idle;
    rd(4'h8, v); chk("R7 avail drops", 32'(v[4]), 0);
    chk("R9 irq drops", 32'(irq), 0);
    for (int i = 0; i < DEPTH/2 - 1; i++) rd(4'h0, v);
    wr(4'h4, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    for (int i = 0; i < DEPTH + 2; i++) push(8'(8'h10 + i));
    idle;
    rd(4'h8, v);
    chk("R5 count at depth", cnt_of(v), DEPTH);
    chk("R5 overflow set", 32'(v[0]), 1);
    chk("R9 irq masked", 32'(irq), 0);
    wr(4'h4, 32'h1); idle;
    chk("R9 irq on overflow", 32'(irq), 1);
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R8 zero write keeps ovf", 32'(v[0]), 1);
    wr(4'h8, 32'h1); idle;
    rd(4'h8, v); chk("R8 ovf cleared", 32'(v[0]), 0);
    chk("R9 irq cleared", 32'(irq), 0);
    wr(4'h4, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'h0, v); chk("R5 kept byte", v, 32'(8'h10 + i));
    end
    rd(4'h8, v); chk("R5 dropped bytes absent", cnt_of(v), 0);
  endtask

  task automatic t_pend;
    logic [31:0] v;
    smp_pkt_end = 1; @(negedge clk); smp_pkt_end = 0;
    rd(4'h8, v); chk("R6 pend set", 32'(v[1]), 1);
    wr(4'h4, 32'h2); idle;
    chk("R9 irq on pend", 32'(irq), 1);
    wr(4'h8, 32'h1);
    rd(4'h8, v); chk("R8 other bit keeps pend", 32'(v[1]), 1);
    wr(4'h8, 32'hFF);
    rd(4'h8, v); chk("R8 0xFF clears all", v & 32'h3, 0);
    wr(4'h4, 0);
  endtask

  task automatic t_full_pushpop;
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
    reg_rd = 1; reg_addr = 4'h0; smp_valid = 1; smp_byte = 8'hEE;
    @(negedge clk); reg_rd = 0; smp_valid = 0; v = reg_rdata;
    chk("R11 popped oldest", v, 32'h40);
    rd(4'h8, v);
    chk("R11 count stays full", cnt_of(v), DEPTH);
    chk("R11 no overflow", 32'(v[0]), 0);
    for (int i = 1; i < DEPTH; i++) begin
      rd(4'h0, v); chk("R11 order", v, 32'(8'h40 + i));
    end
    rd(4'h0, v); chk("R11 new byte last", v, 32'hEE);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", 2000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle;
    t_reset;
    t_order;
    t_ctl;
    t_level;
    t_overflow;
    t_pend;
    t_full_pushpop;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule